// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

This block is the register side of an 8-bit bidirectional I/O port for a small microcontroller. The CPU writes an output latch and a direction register through write strobes and reads either the pin levels or the direction register through read strobes. For each pin the block drives an output-enable and a weak-pull-up enable. Pad circuitry, input synchronisers, bus decoding and the interrupt controller are outside the block. Pin inputs arrive already synchronised to `clk`.

The four upper pins have a change detector. Each of these pins is compared against a snapshot of its level. The snapshot is reloaded on every port read and on every port write. Any upper pin that is configured as an input and differs from its snapshot sets a sticky change flag, and the flag drives a wake request. Software ends the mismatch by touching the port and then clears the flag with a one-cycle pulse. If the mismatch is still present, the flag sets again.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset, `dir_q` is all ones (all inputs), so `oe` is 0x00. `out_val` is 0x00, the pull-up disable bit is 1 so `pu_en` is 0x00, and `chg_flag` and `wake_req` are 0.
- R2: On a cycle with `dir_wr` high, `wdata` loads the direction register. From the next cycle, `oe` bit i is 1 exactly when direction bit i is 0 (1 = input, 0 = output).
- R3: On a cycle with `port_wr` high, `wdata` loads the output latch, and `out_val` shows it from the next cycle. Port reads do not change the latch.
- R4: On a cycle with `pu_wr` high, `pu_off_d` loads the pull-up disable bit. `pu_en` bit i is 1 exactly when that bit is 0 and direction bit i is 1. A pin configured as an output never has its pull-up enabled.
- R5: `rdata` is combinational. It equals `pin_in` on all 8 bits when `port_rd` is high, whatever the direction. It equals the direction register when only `dir_rd` is high, and 0x00 when neither is high. `port_rd` takes priority over `dir_rd`.
- R6: Only bits 7 to 4 that are configured as inputs take part in change detection. A change on bits 3 to 0, or on an upper bit configured as an output, never sets `chg_flag`.
- R7: A mismatch between a participating pin and its snapshot in a cycle sets `chg_flag` in the next cycle.
- R8: On a cycle with `port_rd` or `port_wr` high, the bit 7 to 4 snapshot is loaded from `pin_in`. If the pins then hold steady, no mismatch exists in the next cycle.
- R9: A `flag_clr` pulse clears `chg_flag` in the next cycle, unless a mismatch exists in the same cycle, in which case the flag stays set.
- R10: `wake_req` equals `chg_flag` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 8 | Synchronised pin levels |
| port_wr | input | 1 | Port write strobe (loads output latch, reloads snapshot) |
| port_rd | input | 1 | Port read strobe (reloads snapshot) |
| dir_wr | input | 1 | Direction register write strobe |
| dir_rd | input | 1 | Direction register read strobe |
| pu_wr | input | 1 | Pull-up control write strobe |
| pu_off_d | input | 1 | Pull-up disable value written on `pu_wr` |
| flag_clr | input | 1 | One-cycle change-flag clear pulse |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| out_val | output | 8 | Output latch contents |
| oe | output | 8 | Per-pin output enable |
| pu_en | output | 8 | Per-pin weak pull-up enable |
| chg_flag | output | 1 | Sticky change flag |
| wake_req | output | 1 | Wake-from-sleep request |

## Verification
A corrupted snapshot does not stay hidden. On the cycle after any mismatch it raises `chg_flag` and `wake_req`, or, when the snapshot has been wrongly cleared, it fails to raise them. The bench therefore compares the flag with its model on every cycle.

A wrong direction bit appears at `oe` and `pu_en` one cycle after the write, and at `rdata` as soon as `dir_rd` is asserted. A stuck output latch shows at `out_val` on the cycle after the port write.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int PORT_W = 8;
  localparam int CHG_LO = 4;
  localparam int CHG_N  = PORT_W - CHG_LO;

  typedef logic [PORT_W-1:0] port_t;

  // Bits that take part in change detection.
  function automatic port_t chg_window();
    port_t m;
    for (int i = 0; i < PORT_W; i++) m[i] = (i >= CHG_LO);
    return m;
  endfunction

  // Pull-ups only on inputs, only while the global disable is low.
  function automatic port_t pullup_map(port_t dir, logic pu_off);
    return pu_off ? '0 : dir;
  endfunction

  // Per-pin disagreement between pins and snapshot, restricted to
  // inputs inside the change window.
  function automatic port_t chg_diff(port_t pins, port_t snap, port_t dir);
    return (pins ^ snap) & dir & chg_window();
  endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_chg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  port_wr,
  input  logic  dir_wr,
  input  logic  pu_wr,
  input  logic  pu_off_d,
  input  port_t wdata,
  output port_t out_q,
  output port_t dir_q,
  output logic  pu_off_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else if (port_wr) out_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '1;
    else if (dir_wr) dir_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pu_off_q <= 1'b1;
    else if (pu_wr) pu_off_q <= pu_off_d;
  end
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det
  import gpio_chg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  port_t pin_in,
  input  port_t dir_q,
  input  logic  port_rd,
  input  logic  port_wr,
  input  logic  flag_clr,
  output port_t snap_q,
  output logic  mismatch,
  output logic  flag_q
);
  logic snap_load;
  assign snap_load = port_rd | port_wr;

  for (genvar i = 0; i < PORT_W; i++) begin : g_snap
    if (i >= CHG_LO) begin : g_live
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else if (snap_load) bit_q <= pin_in[i];
      end
      assign snap_q[i] = bit_q;
    end else begin : g_tie
      assign snap_q[i] = 1'b0;
    end
  end

  port_t diff;
  assign diff     = chg_diff(pin_in, snap_q, dir_q);
  assign mismatch = |diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (mismatch) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_in,
  input  logic              port_wr,
  input  logic              port_rd,
  input  logic              dir_wr,
  input  logic              dir_rd,
  input  logic              pu_wr,
  input  logic              pu_off_d,
  input  logic              flag_clr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  output logic [PORT_W-1:0] out_val,
  output logic [PORT_W-1:0] oe,
  output logic [PORT_W-1:0] pu_en,
  output logic              chg_flag,
  output logic              wake_req
);
  port_t dir_q, out_q, snap_q;
  logic  pu_off_q, mismatch, flag_q;

  gpio_port_regs u_regs (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .dir_wr(dir_wr),
    .pu_wr(pu_wr), .pu_off_d(pu_off_d), .wdata(wdata),
    .out_q(out_q), .dir_q(dir_q), .pu_off_q(pu_off_q)
  );

  gpio_chg_det u_det (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir_q(dir_q),
    .port_rd(port_rd), .port_wr(port_wr), .flag_clr(flag_clr),
    .snap_q(snap_q), .mismatch(mismatch), .flag_q(flag_q)
  );

  always_comb begin
    if (port_rd)     rdata = pin_in;
    else if (dir_rd) rdata = dir_q;
    else             rdata = '0;
  end

  assign out_val  = out_q;
  assign oe       = ~dir_q;
  assign pu_en    = pullup_map(dir_q, pu_off_q);
  assign chg_flag = flag_q;
  assign wake_req = flag_q;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk
  import gpio_chg_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input port_t pin_in,
  input logic  port_wr,
  input logic  port_rd,
  input logic  dir_wr,
  input logic  flag_clr,
  input port_t wdata,
  input port_t out_val,
  input port_t oe,
  input port_t pu_en,
  input logic  chg_flag,
  input logic  wake_req,
  input logic  mismatch
);
  assert_latch_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> out_val == $past(wdata));

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> oe == ~$past(wdata));

  assert_no_pullup_on_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en & oe) == '0);

  assert_mismatch_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> chg_flag);

  assert_touch_ends_mismatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(port_rd || port_wr) && !$past(dir_wr) && $stable(pin_in)) |-> !mismatch);

  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !mismatch) |=> !chg_flag);

  assert_wake_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req == chg_flag);
endmodule

bind gpio_chg_port gpio_chg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .port_wr(port_wr),
  .port_rd(port_rd), .dir_wr(dir_wr), .flag_clr(flag_clr), .wdata(wdata),
  .out_val(out_val), .oe(oe), .pu_en(pu_en), .chg_flag(chg_flag),
  .wake_req(wake_req), .mismatch(mismatch)
);

// File: tb/gpio_chg_port_bench.sv
module gpio_chg_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = '0, wdata = '0;
  logic       port_wr = 0, port_rd = 0, dir_wr = 0, dir_rd = 0;
  logic       pu_wr = 0, pu_off_d = 0, flag_clr = 0;
  logic [7:0] rdata, out_val, oe, pu_en;
  logic       chg_flag, wake_req;

  int checks = 0, fails = 0;
  logic [7:0] m_out = 8'h00, m_dir = 8'hFF, m_snap = 8'h00;
  logic       m_pu_off = 1'b1, m_flag = 1'b0;

  always #10 clk = ~clk;

  gpio_chg_port u_gpio_chg_port (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .port_wr(port_wr),
    .port_rd(port_rd), .dir_wr(dir_wr), .dir_rd(dir_rd), .pu_wr(pu_wr),
    .pu_off_d(pu_off_d), .flag_clr(flag_clr), .wdata(wdata), .rdata(rdata),
    .out_val(out_val), .oe(oe), .pu_en(pu_en), .chg_flag(chg_flag),
    .wake_req(wake_req)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Bench view: a pin counts if it is an input and sits in bits 7..4.
  function automatic logic exp_change(logic [7:0] pins, logic [7:0] snap, logic [7:0] dir);
    logic hit = 1'b0;
    for (int b = 4; b < 8; b++)
      if (dir[b] && (pins[b] != snap[b])) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic [7:0] exp_read();
    if (port_rd) return pin_in;
    if (dir_rd)  return m_dir;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_pullups();
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = m_dir[b] & ~m_pu_off;
    return r;
  endfunction

  task automatic check_outs();
    chk(out_val == m_out, "R3", out_val, m_out);
    chk(oe == ~m_dir, "R2", oe, ~m_dir);
    chk(pu_en == exp_pullups(), "R4", pu_en, exp_pullups());
    chk(chg_flag == m_flag, "R7/R9 flag", {7'b0, chg_flag}, {7'b0, m_flag});
    chk(wake_req == chg_flag, "R10", {7'b0, wake_req}, {7'b0, chg_flag});
  endtask

  // Inputs are already set after a negedge. Check rdata, clock, update the model, check outputs.
  task automatic step();
    logic chg;
    #2;
    chk(rdata == exp_read(), "R5", rdata, exp_read());
    chg = exp_change(pin_in, m_snap, m_dir);
    @(posedge clk);
    if (chg) m_flag = 1'b1;
    else if (flag_clr) m_flag = 1'b0;
    if (port_rd || port_wr) m_snap = pin_in & 8'hF0;
    if (port_wr) m_out = wdata;
    if (dir_wr) m_dir = wdata;
    if (pu_wr) m_pu_off = pu_off_d;
    #2;
    check_outs();
    @(negedge clk);
    port_wr = 0; port_rd = 0; dir_wr = 0; dir_rd = 0; pu_wr = 0; flag_clr = 0;
  endtask

  logic done = 1'b0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    chk(oe == 8'h00 && pu_en == 8'h00 && out_val == 8'h00, "R1", oe | pu_en | out_val, 8'h00);
    chk(chg_flag == 0 && wake_req == 0, "R1 flag", {6'b0, chg_flag, wake_req}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed: enable pull-ups and make bits 5:4 outputs.
    pu_wr = 1; pu_off_d = 0; step();
    dir_wr = 1; wdata = 8'hCF; step();
    chk(pu_en == 8'hCF, "R4 directed", pu_en, 8'hCF);
    port_wr = 1; wdata = 8'h30; step();
    chk(out_val == 8'h30, "R3 directed", out_val, 8'h30);
    // A change on a lower pin and on output pin 4 must not set the flag (R6).
    pin_in = 8'h11; step(); step();
    chk(chg_flag == 0, "R6 masked", {7'b0, chg_flag}, 8'h00);
    // A change on input pin 7 sets the flag (R7).
    pin_in = 8'h91; step();
    chk(chg_flag == 1, "R7 directed", {7'b0, chg_flag}, 8'h01);
    // A clear while the mismatch persists leaves the flag set (R9).
    flag_clr = 1; step();
    chk(chg_flag == 1, "R9 set wins", {7'b0, chg_flag}, 8'h01);
    // A read ends the mismatch (R8), after which a clear works (R9).
    port_rd = 1; step();
    flag_clr = 1; step();
    chk(chg_flag == 0, "R8/R9 cleared", {7'b0, chg_flag}, 8'h00);
    dir_rd = 1; step();
    port_rd = 1; dir_rd = 1; step();
    // Random phase.
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(7) == 0) pin_in = 8'($urandom);
      port_rd  = ($urandom_range(5) == 0);
      port_wr  = ($urandom_range(9) == 0);
      dir_wr   = ($urandom_range(15) == 0);
      dir_rd   = ($urandom_range(3) == 0);
      pu_wr    = ($urandom_range(15) == 0);
      pu_off_d = 1'($urandom);
      flag_clr = ($urandom_range(4) == 0);
      wdata    = 8'($urandom);
      step();
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule